// File: doc/BRIEF.md
# Dual-Clock FIFO with Bit-Counted Level Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Its storage holds 4096 data bits, or 4608 for the 9-bit and 18-bit shapes, which carry a spare bit per byte. The `WIDTH` parameter picks the shape, and both ports use that width. Each side keeps a binary pointer one bit wider than the address. The pointer crosses to the other clock as Gray code through a two-stage synchronizer and is converted back to binary there. Full and almost-full are computed in the write domain. Empty and almost-empty are computed in the read domain.

The almost-full and almost-empty thresholds are inputs that may change at run time, and they are counted in data bits rather than words. The block multiplies the word count of each side by `WIDTH` before it compares that count with a threshold, so one threshold format serves every shape. A mode input decides what happens at the limits. In hold mode a write into a full FIFO or a read from an empty FIFO does nothing. In run-on mode the pointers keep advancing, so new words overwrite old ones and a read past the end returns stale words.

Top module: `bitfifo_top`

## Requirements
- R1: While `rst_ni` is low and just after it rises: `empty_o`=1, `full_o`=0, `rdata_o`=0. `afull_o`=0 whenever `af_thresh_i` is nonzero, and `aempty_o`=1.
- R2: Words come out in the order they were written, with no loss or duplication, while both clocks run freely. `rdata_o` takes the word on the read-clock rising edge that performs the read.
- R3: A write into an empty FIFO clears `empty_o` on the second rising edge of `rclk_i` after the write edge. After the first such edge `empty_o` is still 1.
- R4: `empty_o` rises right after the read-clock edge that reads out the last stored word.
- R5: With no reads, `full_o` rises after the write edge of word number DEPTH and is 0 after word DEPTH-1. DEPTH is 512 for `WIDTH`=9, 256 for 18, and 4096/`WIDTH` for 1, 2 and 4.
- R6: `afull_o` is 1 exactly when the write-side word count times `WIDTH` is at least `af_thresh_i`.
- R7: `aempty_o` is 1 exactly when the read-side word count times `WIDTH` is at most `ae_thresh_i`.
- R8: In hold mode (`wrap_mode_i`=0), a write while `full_o`=1 is dropped. No stored word changes and `full_o` stays 1.
- R9: In hold mode, a read while `empty_o`=1 is dropped. The read pointer and `rdata_o` keep their values.
- R10: In run-on mode (`wrap_mode_i`=1), a write while full still advances the write pointer and overwrites the oldest word.
- R11: In run-on mode, a read while empty still advances the read pointer and returns the stale word stored at that address.
- R12: While `blk_ni`=1, neither writes nor reads take effect on either side.
- R13: Pulling `rst_ni` low empties the FIFO at once, without waiting for a clock edge: `empty_o`=1 and `full_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, shared by both domains |
| blk_ni | input | 1 | Block enable, active low |
| wrap_mode_i | input | 1 | 0: hold at full/empty, 1: pointers run on |
| wr_ni | input | 1 | Write enable, active low |
| wdata_i | input | WIDTH | Write data |
| rd_i | input | 1 | Read enable, active high |
| rdata_o | output | WIDTH | Registered read data |
| af_thresh_i | input | 13 | Almost-full threshold in bits |
| ae_thresh_i | input | 13 | Almost-empty threshold in bits |
| full_o | output | 1 | Full, write domain |
| afull_o | output | 1 | Almost full, write domain |
| empty_o | output | 1 | Empty, read domain |
| aempty_o | output | 1 | Almost empty, read domain |

## Verification
The bounded-occupancy and dropped-access properties assume that `wrap_mode_i` keeps the value it had at reset. They also assume that `af_thresh_i` changes only while the FIFO is idle. If the mode were switched while the pointers were already past each other, the hold-mode properties could not hold. The stimulus therefore sets the mode only ahead of a reset pulse and keeps both thresholds fixed for the whole run. Random traffic runs only in hold mode. The writer decides on each write from `full_o` sampled half a cycle earlier and the reader decides on each read from `empty_o`, so the scoreboard matches what the design accepted.

// File: rtl/bitfifo_pkg.sv
`timescale 1ns/100ps
package bitfifo_pkg;
  localparam int unsigned ARRAY_BITS = 4096;
  localparam int unsigned THR_W      = 13;

  // 9- and 18-bit shapes use the array plus one spare bit per byte
  function automatic int unsigned depth_of(input int unsigned w);
    if (w == 9 || w == 18) return (ARRAY_BITS + ARRAY_BITS / 8) / w;
    return ARRAY_BITS / w;
  endfunction
endpackage

// File: rtl/bitfifo_gsync.sv
`timescale 1ns/100ps
module bitfifo_gsync #(
  parameter int unsigned PW     = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [STAGES-1:0][PW-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  for (genvar b = 0; b < PW; b++) begin : g_bin
    assign bin_o[b] = ^stage_q[STAGES-1][PW-1:b];
  end
endmodule

// File: rtl/bitfifo_ptr.sv
`timescale 1ns/100ps
module bitfifo_ptr #(
  parameter int unsigned PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_d;
  assign bin_d = bin_o + PW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end
endmodule

// File: rtl/bitfifo_mem.sv
`timescale 1ns/100ps
module bitfifo_mem #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/bitfifo_top.sv
`timescale 1ns/100ps
module bitfifo_top
  import bitfifo_pkg::*;
#(
  parameter int unsigned WIDTH       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             blk_ni,
  input  logic             wrap_mode_i,
  input  logic             wr_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [THR_W-1:0] af_thresh_i,
  input  logic [THR_W-1:0] ae_thresh_i,
  output logic             full_o,
  output logic             afull_o,
  output logic             empty_o,
  output logic             aempty_o
);
  localparam int unsigned DEPTH  = depth_of(WIDTH);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned PW     = AW + 1;
  localparam int unsigned PROD_W = PW + $clog2(WIDTH) + 1;

  logic          wr_inc, rd_inc;
  logic [PW-1:0] wbin, wgray, rbin, rgray, rbin_w, wbin_r;
  logic [PW-1:0] occ_w, occ_r;

  // write domain
  assign wr_inc = ~blk_ni & ~wr_ni & (wrap_mode_i | ~full_o);

  bitfifo_ptr #(.PW(PW)) u_wptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .inc_i(wr_inc), .bin_o(wbin), .gray_o(wgray)
  );

  bitfifo_gsync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_w)
  );

  assign occ_w   = wbin - rbin_w;
  assign full_o  = occ_w >= PW'(DEPTH);
  assign afull_o = (PROD_W'(occ_w) * PROD_W'(WIDTH)) >= PROD_W'(af_thresh_i);

  // read domain
  assign rd_inc = ~blk_ni & rd_i & (wrap_mode_i | ~empty_o);

  bitfifo_ptr #(.PW(PW)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rst_ni), .inc_i(rd_inc), .bin_o(rbin), .gray_o(rgray)
  );

  bitfifo_gsync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_r)
  );

  assign occ_r    = wbin_r - rbin;
  assign empty_o  = occ_r == '0;
  assign aempty_o = (PROD_W'(occ_r) * PROD_W'(WIDTH)) <= PROD_W'(ae_thresh_i);

  bitfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_inc),
    .waddr_i(wbin[AW-1:0]),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rd_inc),
    .raddr_i(rbin[AW-1:0]),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bitfifo_top_chk.sv
`timescale 1ns/100ps
module bitfifo_top_chk #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned PW    = 10,
  parameter int unsigned THR_W = 13
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             blk_ni,
  input logic             wrap_mode_i,
  input logic             wr_ni,
  input logic             rd_i,
  input logic             full_o,
  input logic             afull_o,
  input logic             empty_o,
  input logic [WIDTH-1:0] rdata_o,
  input logic [THR_W-1:0] af_thresh_i,
  input logic [PW-1:0]    wbin,
  input logic [PW-1:0]    wgray,
  input logic [PW-1:0]    rbin,
  input logic [PW-1:0]    occ_w
);
  AST_WPTR_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin == $past(wbin)) || (wbin == PW'($past(wbin) + 1'b1))); // R2

  AST_GRAY_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wrap_mode_i |-> occ_w <= PW'(DEPTH)); // R5

  AST_AFULL_AT_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && (32'(af_thresh_i) <= DEPTH * WIDTH) |-> afull_o); // R6

  AST_FULL_DROP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wrap_mode_i && full_o && !blk_ni && !wr_ni |=> $stable(wbin)); // R8

  AST_EMPTY_DROP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !wrap_mode_i && empty_o && !blk_ni && rd_i |=> $stable(rbin) && $stable(rdata_o)); // R9

  AST_BLK_WR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    blk_ni |=> $stable(wbin)); // R12

  AST_BLK_RD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    blk_ni |=> $stable(rbin) && $stable(rdata_o)); // R12
endmodule

bind bitfifo_top bitfifo_top_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW), .THR_W(bitfifo_pkg::THR_W)
) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .blk_ni(blk_ni),
  .wrap_mode_i(wrap_mode_i), .wr_ni(wr_ni), .rd_i(rd_i), .full_o(full_o),
  .afull_o(afull_o), .empty_o(empty_o), .rdata_o(rdata_o),
  .af_thresh_i(af_thresh_i), .wbin(wbin), .wgray(wgray), .rbin(rbin), .occ_w(occ_w)
);

// File: tb/bitfifo_top_bench.sv
`timescale 1ns/100ps
module bitfifo_top_bench;
  localparam int W = 9;
  localparam int D = (W == 9) ? 512 : (W == 18) ? 256 : 4096 / W;

  logic wclk_i = 1'b0, rclk_i = 1'b0;
  logic rst_ni, blk_ni, wrap_mode_i, wr_ni, rd_i;
  logic [W-1:0] wdata_i, rdata_o;
  logic [12:0] af_thresh_i, ae_thresh_i;
  logic full_o, afull_o, empty_o, aempty_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit wr_done;
  logic [W-1:0] sb_q[$];
  logic [W-1:0] last_v;

  always #10   wclk_i = ~wclk_i;
  always #13.7 rclk_i = ~rclk_i;

  bitfifo_top #(.WIDTH(W)) u_bitfifo_top (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .blk_ni(blk_ni),
    .wrap_mode_i(wrap_mode_i), .wr_ni(wr_ni), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .af_thresh_i(af_thresh_i), .ae_thresh_i(ae_thresh_i),
    .full_o(full_o), .afull_o(afull_o), .empty_o(empty_o), .aempty_o(aempty_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [W-1:0] d);
    @(negedge wclk_i); wdata_i = d; wr_ni = 1'b0;
    @(posedge wclk_i); #1 wr_ni = 1'b1;
  endtask

  task automatic do_read();
    @(negedge rclk_i); rd_i = 1'b1;
    @(posedge rclk_i); #1 rd_i = 1'b0;
  endtask

  task automatic idle_r(input int n);
    repeat (n) @(posedge rclk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge wclk_i); #3 rst_ni = 1'b0;
    #1;
    chk("R13 empty", empty_o, 1);
    chk("R13 full", full_o, 0);
    #60;
    @(negedge wclk_i); #3 rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge wclk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; blk_ni = 1'b0; wrap_mode_i = 1'b0; wr_ni = 1'b1; rd_i = 1'b0;
    wdata_i = '0; af_thresh_i = 13'd900; ae_thresh_i = 13'd45;
    #50;
    chk("R1 empty", empty_o, 1); chk("R1 full", full_o, 0);
    chk("R1 afull", afull_o, 0); chk("R1 aempty", aempty_o, 1);
    chk("R1 rdata", rdata_o, 0);
    @(negedge wclk_i); #3 rst_ni = 1'b1;
    idle_r(3);
    chk("R1 empty after release", empty_o, 1);

    // R3: two-edge empty latency
    @(negedge wclk_i); wdata_i = 9'h0A5; wr_ni = 1'b0;
    @(posedge wclk_i);
    fork begin #1 wr_ni = 1'b1; end join_none
    @(posedge rclk_i); #1 chk("R3 first edge", empty_o, 1);
    @(posedge rclk_i); #1 chk("R3 second edge", empty_o, 0);

    // R4 / R2
    do_read();
    chk("R2 data", rdata_o, 9'h0A5);
    chk("R4 empty on last read", empty_o, 1);

    // R9: read on empty dropped
    do_read();
    chk("R9 rdata kept", rdata_o, 9'h0A5);
    do_write(9'h111);
    idle_r(3);
    do_read();
    chk("R9 pointer kept", rdata_o, 9'h111);

    // R5 / R6: fill
    for (int k = 1; k <= D; k++) begin
      do_write(W'((k * 37 + 5) % 512));
      if (k == 99)    chk("R6 afull below", afull_o, 0);
      if (k == 100)   chk("R6 afull at", afull_o, 1);
      if (k == D - 1) chk("R5 not full", full_o, 0);
      if (k == D)     chk("R5 full", full_o, 1);
    end
    // R8: writes while full dropped
    repeat (3) do_write(9'h1FF);
    chk("R8 full kept", full_o, 1);

    // drain, R2 / R7
    idle_r(4);
    for (int k = 1; k <= D; k++) begin
      do_read();
      chk("R2 R8 order", rdata_o, (k * 37 + 5) % 512);
      if (D - k == 6) chk("R7 aempty above", aempty_o, 0);
      if (D - k == 5) chk("R7 aempty at", aempty_o, 1);
    end
    chk("R4 empty after drain", empty_o, 1);
    last_v = rdata_o;

    // R12: block disable
    blk_ni = 1'b1;
    do_write(9'h0C3);
    idle_r(4);
    chk("R12 write blocked", empty_o, 1);
    blk_ni = 1'b0;
    do_write(9'h0C3);
    idle_r(4);
    blk_ni = 1'b1;
    do_read();
    chk("R12 read blocked empty", empty_o, 0);
    chk("R12 read blocked rdata", rdata_o, last_v);
    blk_ni = 1'b0;
    do_read();
    chk("R12 read after enable", rdata_o, 9'h0C3);

    // random traffic in hold mode, R2 / R8 / R9
    wr_done = 1'b0;
    fork
      begin
        for (int i = 0; i < 2500; i++) begin
          @(negedge wclk_i);
          if ($urandom % 4 != 0) begin
            wdata_i = W'($urandom);
            wr_ni = 1'b0;
            if (!full_o) sb_q.push_back(wdata_i);
          end else wr_ni = 1'b1;
        end
        @(negedge wclk_i); wr_ni = 1'b1; wr_done = 1'b1;
      end
      begin
        logic [W-1:0] exp_v;
        bit pend;
        pend = 1'b0; exp_v = '0;
        forever begin
          @(negedge rclk_i);
          if (pend) begin chk("R2 random order", rdata_o, exp_v); pend = 1'b0; end
          if (wr_done && sb_q.size() == 0) begin rd_i = 1'b0; break; end
          rd_i = ($urandom % 3 != 0);
          if (rd_i && !empty_o && sb_q.size() != 0) begin
            exp_v = sb_q.pop_front(); pend = 1'b1;
          end
        end
      end
    join
    idle_r(4);
    chk("R4 empty after random", empty_o, 1);

    // R10: run-on overflow overwrites oldest
    wrap_mode_i = 1'b1;
    do_reset();
    for (int k = 0; k < D; k++) do_write(W'(k));
    do_write(9'h155);
    idle_r(4);
    do_read();
    chk("R10 overwrite", rdata_o, 9'h155);

    // R13 then R11: run-on read from empty returns stale word
    do_reset();
    idle_r(3);
    do_read();
    chk("R11 stale read", rdata_o, 9'h155);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule